// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block turns an active-low external reset pin into the internal reset sequence of a device that holds both memory and programmable logic. It tells a power-on reset apart from a reset of a running device. After the supply becomes good, a reset pulse is honoured only if it lasts at least a long cold minimum. Once the device has been configured, a much shorter pulse is enough. Pulses shorter than the minimum that applies in the current state are ignored.

A qualified cold pulse starts a configuration load. The logic outputs are marked valid only when that load completes, and they stay valid through every later warm reset. After the pin is released, every reset passes through a common hold-off window before memory access is granted. The hold-off also waits for any interrupted flash program or erase to wind down. While the device is in reset and the flash reports busy, the block drives an abort request. Flash write strobes are inhibited whenever the device is not running or the supply is below the write-lockout level. Dropping the supply-good flag returns the block to its powered-off state at once, from any state.

Top module: `reset_sequencer`

## Requirements
- R1: While supplyGood is low (asynchronously, from any state), intReset=1, accessReady=0, logicValid=0, cfgLoadStart=0 and writeInhibit=1.
- R2: After power-up, a low pulse on rstPinN is accepted as a cold reset only if it lasts at least T_PO clock cycles. An accepted pulse makes cfgLoadStart high for exactly one cycle, T_PO+3 cycles after the pin falls (two synchroniser stages plus counting). A shorter pulse produces no cfgLoadStart and no access.
- R3: logicValid rises exactly T_CFG cycles after the cfgLoadStart cycle. It then stays high, including through warm resets, until supplyGood falls.
- R4: After a cold reset, accessReady first rises at cycle max(T_PO+T_CFG+4, L+3)+T_OPR, counted from the pin's fall, where L is the pulse length. This is T_OPR cycles of hold-off that start once configuration is done and the synchronised pin is high.
- R5: While running, a low pulse of at least T_WARM cycles drops accessReady T_WARM+3 cycles after the fall. A shorter pulse leaves accessReady high on every cycle.
- R6: After an accepted warm pulse of length L, accessReady returns at cycle L+3+T_OPR after the fall. This is the same T_OPR hold-off as after a cold reset.
- R7: flashAbort is high exactly when the device is not running and flashBusy is high; it is never high while accessReady is high. The hold-off does not end while flashBusy is high.
- R8: writeInhibit is high whenever aboveLockout is low or accessReady is low, and low otherwise.
- R9: accessReady is high only in the running state, where intReset is low. accessReady implies logicValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supplyGood | input | 1 | Supply is steady; low forces the powered-off state asynchronously |
| rstPinN | input | 1 | External active-low reset pin, asynchronous |
| aboveLockout | input | 1 | Supply is above the flash write-lockout level |
| flashBusy | input | 1 | Flash program or erase in progress |
| intReset | output | 1 | Internal reset, high in every state but running |
| cfgLoadStart | output | 1 | One-cycle start of the configuration load |
| flashAbort | output | 1 | Request to end the flash operation and return to read mode |
| writeInhibit | output | 1 | Blocks flash write strobes |
| accessReady | output | 1 | Memory access allowed |
| logicValid | output | 1 | Logic outputs valid (configuration loaded) |

## Verification
On every cycle, the assertions check the following: the configuration start is a single-cycle pulse that comes before validity; validity is sticky; every rise of access-ready follows at least T_OPR reset cycles and an idle flash; and lockout or a busy abort never coexists with a permitted write or access. Only the bench's scenarios can show the exact acceptance thresholds. These are the boundary between T_PO-1 and T_PO cycles for a cold pulse and between T_WARM-1 and T_WARM cycles for a warm pulse. The scenarios also show the precise latencies from pin edges to configuration start, validity and readiness, and the extension of the hold-off while the flash remains busy.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    POWER_OFF   = 3'd0,
    COLD_RESET  = 3'd1,
    CONFIG_LOAD = 3'd2,
    HOLDOFF     = 3'd3,
    RUN         = 3'd4,
    WARM_RESET  = 3'd5
  } seqState_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic clrPhase;
    logic setCfg;
  } seqStrobe_t;

  // conditions reported by the datapath to control
  typedef struct packed {
    logic pinHigh;
    logic coldMet;
    logic warmMet;
    logic phaseZero;
    logic cfgDone;
    logic oprDone;
    logic cfgLoaded;
  } seqFlags_t;

endpackage

// File: rtl/rstseq_datapath.sv
module rstseq_datapath
  import rstseq_pkg::*;
#(
  parameter int T_PO        = 1000,
  parameter int T_WARM      = 16,
  parameter int T_OPR       = 200,
  parameter int T_CFG       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       rstPinN,
  input  seqStrobe_t strobe,
  output seqFlags_t  flags
);

  localparam int LOW_W  = $clog2(T_PO + 1);
  localparam int PH_MAX = (T_CFG > T_OPR) ? T_CFG : T_OPR;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  localparam logic [LOW_W-1:0] COLD_MIN = LOW_W'(T_PO);
  localparam logic [LOW_W-1:0] WARM_MIN = LOW_W'(T_WARM);
  localparam logic [PH_W-1:0]  CFG_LAST = PH_W'(T_CFG - 1);
  localparam logic [PH_W-1:0]  OPR_LAST = PH_W'(T_OPR - 1);
  localparam logic [PH_W-1:0]  PH_TOP   = PH_W'(PH_MAX);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [LOW_W-1:0]       lowCnt;
  logic [PH_W-1:0]        phaseCnt;
  logic                   cfgLoaded;
  logic                   pinSync;

  // pin synchroniser, released level on power-off
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge supplyGood) begin
        if (!supplyGood) syncChain <= '1;
        else             syncChain <= rstPinN;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge supplyGood) begin
        if (!supplyGood) syncChain <= '1;
        else             syncChain <= {syncChain[SYNC_STAGES-2:0], rstPinN};
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  // consecutive low cycles of the synchronised pin, saturating
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)           lowCnt <= '0;
    else if (pinSync)          lowCnt <= '0;
    else if (lowCnt != COLD_MIN) lowCnt <= lowCnt + 1'b1;
  end

  // shared timer for configuration load and hold-off
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)             phaseCnt <= '0;
    else if (strobe.clrPhase)    phaseCnt <= '0;
    else if (phaseCnt != PH_TOP) phaseCnt <= phaseCnt + 1'b1;
  end

  // configuration loaded: survives warm resets, cleared by supply loss
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)        cfgLoaded <= 1'b0;
    else if (strobe.setCfg) cfgLoaded <= 1'b1;
  end

  always_comb begin
    flags.pinHigh   = pinSync;
    flags.coldMet   = (lowCnt >= COLD_MIN);
    flags.warmMet   = (lowCnt >= WARM_MIN);
    flags.phaseZero = (phaseCnt == '0);
    flags.cfgDone   = (phaseCnt == CFG_LAST);
    flags.oprDone   = (phaseCnt >= OPR_LAST);
    flags.cfgLoaded = cfgLoaded;
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       aboveLockout,
  input  logic       flashBusy,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       intReset,
  output logic       cfgLoadStart,
  output logic       flashAbort,
  output logic       writeInhibit,
  output logic       accessReady,
  output logic       logicValid
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) state <= POWER_OFF;
    else             state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobe.clrPhase = 1'b0;
    strobe.setCfg   = 1'b0;
    unique case (state)
      POWER_OFF: nextState = COLD_RESET;
      COLD_RESET: begin
        if (flags.coldMet) begin
          nextState       = CONFIG_LOAD;
          strobe.clrPhase = 1'b1;
        end
      end
      CONFIG_LOAD: begin
        strobe.setCfg = flags.cfgDone && !flags.cfgLoaded;
        if (flags.cfgLoaded && flags.pinHigh) begin
          nextState       = HOLDOFF;
          strobe.clrPhase = 1'b1;
        end
      end
      HOLDOFF: begin
        if (flags.warmMet) begin
          // a fresh qualified pulse restarts the window
          nextState       = flags.pinHigh ? HOLDOFF : WARM_RESET;
          strobe.clrPhase = 1'b1;
        end else if (flags.oprDone && !flashBusy) begin
          nextState = RUN;
        end
      end
      RUN: begin
        if (flags.warmMet) begin
          nextState       = flags.pinHigh ? HOLDOFF : WARM_RESET;
          strobe.clrPhase = 1'b1;
        end
      end
      WARM_RESET: begin
        if (flags.pinHigh) begin
          nextState       = HOLDOFF;
          strobe.clrPhase = 1'b1;
        end
      end
      default: nextState = POWER_OFF;
    endcase
  end

  always_comb begin
    accessReady  = (state == RUN);
    intReset     = !accessReady;
    cfgLoadStart = (state == CONFIG_LOAD) && flags.phaseZero;
    flashAbort   = intReset && flashBusy;
    writeInhibit = intReset || !aboveLockout;
    logicValid   = flags.cfgLoaded;
  end

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int T_PO        = 1000,
  parameter int T_WARM      = 16,
  parameter int T_OPR       = 200,
  parameter int T_CFG       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic supplyGood,
  input  logic rstPinN,
  input  logic aboveLockout,
  input  logic flashBusy,
  output logic intReset,
  output logic cfgLoadStart,
  output logic flashAbort,
  output logic writeInhibit,
  output logic accessReady,
  output logic logicValid
);

  seqStrobe_t strobe;
  seqFlags_t  flags;

  rstseq_datapath #(
    .T_PO(T_PO), .T_WARM(T_WARM), .T_OPR(T_OPR), .T_CFG(T_CFG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .supplyGood(supplyGood), .rstPinN(rstPinN),
    .strobe(strobe), .flags(flags)
  );

  rstseq_ctrl u_ctrl (
    .clk(clk), .supplyGood(supplyGood), .aboveLockout(aboveLockout),
    .flashBusy(flashBusy), .flags(flags), .strobe(strobe),
    .intReset(intReset), .cfgLoadStart(cfgLoadStart),
    .flashAbort(flashAbort), .writeInhibit(writeInhibit),
    .accessReady(accessReady), .logicValid(logicValid)
  );

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int T_OPR = 200
) (
  input logic clk,
  input logic supplyGood,
  input logic aboveLockout,
  input logic flashBusy,
  input logic intReset,
  input logic cfgLoadStart,
  input logic flashAbort,
  input logic writeInhibit,
  input logic accessReady,
  input logic logicValid
);

  localparam int HC_W = $clog2(T_OPR + 1);
  localparam logic [HC_W-1:0] HC_TOP = HC_W'(T_OPR);

  logic [HC_W-1:0] holdCnt;

  // consecutive cycles spent in reset, saturating at T_OPR
  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)           holdCnt <= '0;
    else if (!intReset)        holdCnt <= '0;
    else if (holdCnt != HC_TOP) holdCnt <= holdCnt + 1'b1;
  end

  assert_cfg_single_R2: assert property (@(posedge clk) disable iff (!supplyGood)
    cfgLoadStart |=> !cfgLoadStart);

  assert_cfg_before_valid_R3: assert property (@(posedge clk) disable iff (!supplyGood)
    cfgLoadStart |-> !logicValid);

  assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (!supplyGood)
    logicValid |=> logicValid);

  assert_holdoff_len_R4: assert property (@(posedge clk) disable iff (!supplyGood)
    $rose(accessReady) |-> (holdCnt >= HC_TOP));

  assert_idle_flash_R7: assert property (@(posedge clk) disable iff (!supplyGood)
    $rose(accessReady) |-> !$past(flashBusy));

  assert_no_abort_ready_R7: assert property (@(posedge clk) disable iff (!supplyGood)
    accessReady |-> !flashAbort);

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!supplyGood)
    !aboveLockout |-> writeInhibit);

  assert_ready_valid_R9: assert property (@(posedge clk) disable iff (!supplyGood)
    accessReady |-> logicValid);

endmodule

bind reset_sequencer rstseq_checker #(.T_OPR(T_OPR)) u_rstseq_chk (
  .clk(clk), .supplyGood(supplyGood), .aboveLockout(aboveLockout),
  .flashBusy(flashBusy), .intReset(intReset), .cfgLoadStart(cfgLoadStart),
  .flashAbort(flashAbort), .writeInhibit(writeInhibit),
  .accessReady(accessReady), .logicValid(logicValid)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;

  localparam int T_PO   = 8;
  localparam int T_WARM = 3;
  localparam int T_OPR  = 5;
  localparam int T_CFG  = 4;

  logic clk = 1'b0;
  logic supplyGood = 1'b0;
  logic rstPinN = 1'b1;
  logic aboveLockout = 1'b1;
  logic flashBusy = 1'b0;
  logic intReset, cfgLoadStart, flashAbort, writeInhibit, accessReady, logicValid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int idxCfg, idxValid, idxRdy, idxFall, idxAbort;
  int cfgCount, readyLow, validLow, abortInRun, inhibitErr, readyResetErr;

  always #2.5 clk = ~clk;

  reset_sequencer #(.T_PO(T_PO), .T_WARM(T_WARM), .T_OPR(T_OPR), .T_CFG(T_CFG))
  u_reset_sequencer (
    .clk(clk), .supplyGood(supplyGood), .rstPinN(rstPinN),
    .aboveLockout(aboveLockout), .flashBusy(flashBusy),
    .intReset(intReset), .cfgLoadStart(cfgLoadStart), .flashAbort(flashAbort),
    .writeInhibit(writeInhibit), .accessReady(accessReady), .logicValid(logicValid)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic powerUp();
    @(negedge clk);
    supplyGood = 1'b0; rstPinN = 1'b1; flashBusy = 1'b0; aboveLockout = 1'b1;
    repeat (2) @(negedge clk);
    supplyGood = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // pin falls now (at a falling clock edge), rises after L cycles
  task automatic pulseRun(input int L, input int nCyc, input int busyOffAt);
    idxCfg = -1; idxValid = -1; idxRdy = -1; idxFall = -1; idxAbort = -1;
    cfgCount = 0; readyLow = 0; validLow = 0;
    rstPinN = 1'b0;
    for (int i = 1; i <= nCyc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (cfgLoadStart) begin
        cfgCount++;
        if (idxCfg < 0) idxCfg = i;
      end
      if (logicValid && idxValid < 0) idxValid = i;
      if (!logicValid) validLow++;
      if (!accessReady) begin
        readyLow++;
        if (idxFall < 0) idxFall = i;
      end else if (idxRdy < 0 && readyLow > 0) idxRdy = i;
      if (flashAbort && idxAbort < 0) idxAbort = i;
      if (flashAbort && accessReady) abortInRun++;
      if (writeInhibit != (!accessReady || !aboveLockout)) inhibitErr++;
      if (intReset == accessReady) readyResetErr++;
      if (i == L) rstPinN = 1'b1;
      if (i == busyOffAt) flashBusy = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1-R9 scope actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    abortInRun = 0; inhibitErr = 0; readyResetErr = 0;
    @(negedge clk);
    // R1: reset state while supply is not good
    chkEq("R1 intReset", int'(intReset), 1);
    chkEq("R1 accessReady", int'(accessReady), 0);
    chkEq("R1 logicValid", int'(logicValid), 0);
    chkEq("R1 cfgLoadStart", int'(cfgLoadStart), 0);
    chkEq("R1 writeInhibit", int'(writeInhibit), 1);

    // R2 R3 R4: cold pulse length sweep
    for (int L = 1; L <= 12; L++) begin
      powerUp();
      pulseRun(L, 60, -1);
      if (L >= T_PO) begin
        chkEq("R2 cfg pulses", cfgCount, 1);
        chkEq("R2 cfg start cycle", idxCfg, T_PO + 3);
        chkEq("R3 cfg to valid", idxValid - idxCfg, T_CFG);
        chkEq("R4 cold ready cycle", idxRdy,
              ((T_PO + T_CFG + 4 > L + 3) ? T_PO + T_CFG + 4 : L + 3) + T_OPR);
      end else begin
        chkEq("R2 short cfg pulses", cfgCount, 0);
        chkEq("R2 short no ready", idxRdy, -1);
        chkEq("R2 short no valid", idxValid, -1);
      end
    end

    // R1: supply loss from running state is immediate
    chkEq("R1 running before loss", int'(accessReady), 1);
    supplyGood = 1'b0;
    #1;
    chkEq("R1 loss ready", int'(accessReady), 0);
    chkEq("R1 loss valid", int'(logicValid), 0);
    chkEq("R1 loss reset", int'(intReset), 1);

    // R5 R6: warm pulse sweep
    powerUp();
    pulseRun(T_PO, 40, -1);
    chkEq("R5 running before warm sweep", int'(accessReady), 1);
    for (int L = 1; L <= 6; L++) begin
      repeat (3) @(negedge clk);
      pulseRun(L, 30, -1);
      chkEq("R3 valid kept in warm", validLow, 0);
      if (L < T_WARM) begin
        chkEq("R5 short warm ignored", readyLow, 0);
      end else begin
        chkEq("R5 warm drop cycle", idxFall, T_WARM + 3);
        chkEq("R6 warm ready cycle", idxRdy, L + 3 + T_OPR);
      end
    end

    // R7: abort while flash busy, hold-off extended
    flashBusy = 1'b1;
    repeat (2) @(negedge clk);
    chkEq("R7 no abort while running", int'(flashAbort), 0);
    abortInRun = 0;
    pulseRun(5, 30, 20);
    chkEq("R7 abort cycle", idxAbort, T_WARM + 3);
    chkEq("R7 ready waits for flash", idxRdy, 21);
    chkEq("R7 abort never with ready", abortInRun, 0);

    // R8: lockout
    aboveLockout = 1'b0;
    #1;
    chkEq("R8 lockout inhibits", int'(writeInhibit), 1);
    aboveLockout = 1'b1;
    #1;
    chkEq("R8 above lockout running", int'(writeInhibit), 0);
    chkEq("R8 inhibit consistency", inhibitErr, 0);
    chkEq("R9 ready vs intReset", readyResetErr, 0);

    finishRun();
  end

endmodule